// File: doc/BRIEF.md
# Serial Programming Command Receiver

This block is the target-side receiver of a two-wire serial programming port. An external host toggles a programming clock pin and drives a shared data pin. The block samples both pins in its own, much faster system clock domain, turns the sampled clock into rise and fall events, and collects six-bit commands from the data pin. It then issues single-cycle strobes to an attached memory and address unit. That unit and the memory array live outside the block.

Two of the commands, write-word and fetch-word, are followed by a sixteen-clock data frame. The first clock of the frame is a start slot and the last is a stop slot; the fourteen clocks between them carry data, least significant bit first. For a write, the block collects the data bits and hands the low twelve to the memory unit. For a fetch, it captures the memory word and drives the data pin through an output enable over a fixed window of rising edges. A one-cycle mode-entry reset returns the receiver to the command phase at any point.

Top module: `prog_cmd_slave`

## Requirements
- R1: A command is six programming clocks long. One data bit is taken at each falling edge of the programming clock, and the first bit taken is bit 0 of the command.
- R2: Only command bits 3..0 are decoded; bits 5..4 have no effect. The codes are: 4'b0010 write-word, 4'b0100 fetch-word, 4'b0110 step address (`inc_stb`), 4'b1000 start program (`prog_begin_stb`), 4'b1110 stop program (`prog_end_stb`) and 4'b1001 bulk erase (`erase_stb`). Each strobe is high for exactly one system clock.
- R3: Only write-word and fetch-word are followed by a 16-clock data frame. Data on the pin during the start slot (clock 1) and the stop slot (clock 16) has no effect. After the falling edge of clock 16 the next six clocks form a command.
- R4: For write-word, the 14 data bits arrive LSB first in clocks 2..15. `load_word` takes data bits 11..0 and `load_stb` pulses after the falling edge of the stop slot. Data bits 13..12 are discarded.
- R5: For fetch-word, `read_stb` pulses when the command is decoded, and `mem_rdata` is captured at the rising edge of frame clock 1. `pdat_oe` rises with the rising edge of frame clock 2 and falls with the rising edge of frame clock 16. Data bit k is driven from the rising edge of clock k+2, and bits 13..12 are driven as 0. `pdat_out` is 0 whenever `pdat_oe` is 0.
- R6: A start-program command gives `prog_begin_stb` only if a write-word has completed since the last start-program command or mode-entry reset. Otherwise it gives a one-cycle `seq_err` pulse and no `prog_begin_stb`.
- R7: A command whose bits 3..0 match no code produces no strobe and no data frame; the next six clocks form a command.
- R8: While `mode_rst` is high, the receiver returns to the command phase with a cleared bit count, drops `pdat_oe` and forgets any pending write-word.
- R9: After `rst`, all strobes, `seq_err`, `pdat_oe`, `pdat_out` and `load_word` are 0.
- R10: Every output responds on the third system clock edge that follows the pin transition causing it: the first edge that samples the new pin level counts as the first. The system clock must be at least 8 times faster than the programming clock.
- R11: At most one of the six strobes and `seq_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_rst | input | 1 | Mode-entry reset, one or more system cycles high |
| pclk_pin | input | 1 | Programming clock pin from the host (asynchronous) |
| pdat_pin | input | 1 | Data pin input from the host (asynchronous) |
| mem_rdata | input | 12 | Word at the current address, from the memory unit |
| pdat_out | output | 1 | Data pin output value |
| pdat_oe | output | 1 | Data pin output enable |
| load_stb | output | 1 | Write-word frame complete, `load_word` valid |
| load_word | output | 12 | Received word (data bits 11..0) |
| read_stb | output | 1 | Fetch-word decoded; memory unit presents `mem_rdata` |
| inc_stb | output | 1 | Step address |
| prog_begin_stb | output | 1 | Start programming the current location |
| prog_end_stb | output | 1 | Stop programming |
| erase_stb | output | 1 | Bulk erase |
| seq_err | output | 1 | Start-program refused, no write-word since the last one |

## Verification
The embedded properties check several rules on every cycle. At most one strobe is active at a time. A start-program strobe happens only while a write-word is pending, and an error pulse only when none is pending. The output enable stays inside a fetch frame, and the output value never stands without the enable. A mode-entry reset always lands in the command phase, and the bit count stays in range during commands. What the properties cannot show needs the bench's scenarios and its clock-by-clock reference model. That covers LSB-first assembly of commands and words, and discarding of the top command and data bits. It also covers the exact rising edges that open and close the output window, the three-cycle response latency, and recovery from a mode-entry reset in the middle of a command or a frame.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_LOAD = 2'd1,
    PH_READ = 2'd2
  } phase_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_LOAD,
    ACT_READ,
    ACT_INC,
    ACT_BEGIN,
    ACT_END,
    ACT_ERASE
  } act_t;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'b0010;
  localparam logic [OP_W-1:0] OP_READ  = 4'b0100;
  localparam logic [OP_W-1:0] OP_INC   = 4'b0110;
  localparam logic [OP_W-1:0] OP_BEGIN = 4'b1000;
  localparam logic [OP_W-1:0] OP_END   = 4'b1110;
  localparam logic [OP_W-1:0] OP_ERASE = 4'b1001;

  function automatic act_t decode_op(input logic [OP_W-1:0] op);
    act_t a;
    case (op)
      OP_LOAD:  a = ACT_LOAD;
      OP_READ:  a = ACT_READ;
      OP_INC:   a = ACT_INC;
      OP_BEGIN: a = ACT_BEGIN;
      OP_END:   a = ACT_END;
      OP_ERASE: a = ACT_ERASE;
      default:  a = ACT_NONE;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/pcs_pin_sync.sv
module pcs_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pclk_pin,
  input  logic pdat_pin,
  output logic pclk_rise,
  output logic pclk_fall,
  output logic pdat_s
);

  logic [STAGES-1:0] clk_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              clk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
      clk_last <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-2:0], pclk_pin};
      dat_pipe <= {dat_pipe[STAGES-2:0], pdat_pin};
      clk_last <= clk_pipe[STAGES-1];
    end
  end

  assign pclk_rise = clk_pipe[STAGES-1] & ~clk_last;
  assign pclk_fall = ~clk_pipe[STAGES-1] & clk_last;
  assign pdat_s    = dat_pipe[STAGES-1];

endmodule

// File: rtl/pcs_frame.sv
module pcs_frame
  import pcs_pkg::*;
#(
  parameter int CMD_BITS  = 6,
  parameter int DATA_BITS = 14,
  parameter int WORD_BITS = 12,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_rst,
  input  logic                 fall,
  input  logic                 dat,
  output phase_t               phase,
  output logic [CNT_W-1:0]     cnt,
  output logic                 load_stb,
  output logic [WORD_BITS-1:0] load_word,
  output logic                 read_stb,
  output logic                 inc_stb,
  output logic                 prog_begin_stb,
  output logic                 prog_end_stb,
  output logic                 erase_stb,
  output logic                 seq_err
);

  localparam int              FRAME_CLKS = DATA_BITS + 2;
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_CLKS - 1);
  localparam logic [CNT_W-1:0] WORD_LAST  = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] OP_LAST    = CNT_W'(OP_W);

  logic [OP_W-1:0]      op_sr;
  logic [WORD_BITS-1:0] wsr;
  logic                 armed;

  always_ff @(posedge clk) begin
    load_stb       <= 1'b0;
    read_stb       <= 1'b0;
    inc_stb        <= 1'b0;
    prog_begin_stb <= 1'b0;
    prog_end_stb   <= 1'b0;
    erase_stb      <= 1'b0;
    seq_err        <= 1'b0;
    if (rst) begin
      phase     <= PH_CMD;
      cnt       <= '0;
      op_sr     <= '0;
      wsr       <= '0;
      armed     <= 1'b0;
      load_word <= '0;
    end else if (mode_rst) begin
      phase <= PH_CMD;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (fall) begin
      if (phase == PH_CMD) begin
        // command bits arrive LSB first; only the decoded low bits are kept
        if (cnt < OP_LAST) op_sr[cnt[1:0]] <= dat;
        if (cnt == CMD_LAST) begin
          cnt <= '0;
          case (decode_op(op_sr))
            ACT_LOAD:  phase <= PH_LOAD;
            ACT_READ: begin
              phase    <= PH_READ;
              read_stb <= 1'b1;
            end
            ACT_INC:   inc_stb <= 1'b1;
            ACT_BEGIN: begin
              if (armed) begin
                prog_begin_stb <= 1'b1;
                armed          <= 1'b0;
              end else begin
                seq_err <= 1'b1;
              end
            end
            ACT_END:   prog_end_stb <= 1'b1;
            ACT_ERASE: erase_stb    <= 1'b1;
            default:   ;
          endcase
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else begin
        // data frame: slot 0 start, slots 1..DATA_BITS data, last slot stop
        if (cnt >= CNT_W'(1) && cnt <= WORD_LAST)
          wsr <= {dat, wsr[WORD_BITS-1:1]};
        if (cnt == FRAME_LAST) begin
          phase <= PH_CMD;
          cnt   <= '0;
          if (phase == PH_LOAD) begin
            load_stb  <= 1'b1;
            load_word <= wsr;
            armed     <= 1'b1;
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R11: strobes never overlap
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_stb, read_stb, inc_stb, prog_begin_stb, prog_end_stb, erase_stb, seq_err}));

  // R6: program strobe only with a pending word, error only without
  p_begin_armed_r6: assert property (@(posedge clk) disable iff (rst)
    prog_begin_stb |-> $past(armed));
  p_err_unarmed_r6: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> !$past(armed));

  // R1: bit count stays inside a command
  p_cmd_count_r1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CMD) |-> (cnt <= CMD_LAST));

  // R4: a word is delivered only from a write frame
  p_load_from_frame_r4: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> ($past(phase) == PH_LOAD));

  // R5: fetch strobe opens a fetch frame
  p_read_enters_r5: assert property (@(posedge clk) disable iff (rst)
    read_stb |-> (phase == PH_READ));

  // R8: mode-entry reset lands in the command phase
  p_mode_rst_r8: assert property (@(posedge clk) disable iff (rst)
    mode_rst |=> (phase == PH_CMD && cnt == '0 && !armed));

endmodule

// File: rtl/pcs_tx.sv
module pcs_tx #(
  parameter int DATA_BITS = 14,
  parameter int WORD_BITS = 12,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_rst,
  input  logic                 rise,
  input  logic                 in_read,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [WORD_BITS-1:0] mem_rdata,
  output logic                 pdat_out,
  output logic                 pdat_oe
);

  localparam int               PAD       = DATA_BITS - WORD_BITS;
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BITS);

  logic [DATA_BITS-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr    <= '0;
      pdat_out <= 1'b0;
      pdat_oe  <= 1'b0;
    end else if (mode_rst || !in_read) begin
      pdat_out <= 1'b0;
      pdat_oe  <= 1'b0;
    end else if (rise) begin
      if (cnt == '0) begin
        // start slot: capture word, pad top bits with zero
        tx_sr <= {{PAD{1'b0}}, mem_rdata};
      end else if (cnt <= DATA_LAST) begin
        pdat_oe  <= 1'b1;
        pdat_out <= tx_sr[0];
        tx_sr    <= tx_sr >> 1;
      end else begin
        pdat_oe  <= 1'b0;
        pdat_out <= 1'b0;
      end
    end
  end

  // R5: output enable only inside a fetch frame
  p_oe_in_read_r5: assert property (@(posedge clk) disable iff (rst)
    pdat_oe |-> $past(in_read));

  // R5: no output value without the enable
  p_out_gated_r5: assert property (@(posedge clk) disable iff (rst)
    pdat_out |-> pdat_oe);

  // R8: mode-entry reset releases the pin
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    mode_rst |=> !pdat_oe);

endmodule

// File: rtl/prog_cmd_slave.sv
module prog_cmd_slave
  import pcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CMD_BITS    = 6,
  parameter int DATA_BITS   = 14,
  parameter int WORD_BITS   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_rst,
  input  logic                 pclk_pin,
  input  logic                 pdat_pin,
  input  logic [WORD_BITS-1:0] mem_rdata,
  output logic                 pdat_out,
  output logic                 pdat_oe,
  output logic                 load_stb,
  output logic [WORD_BITS-1:0] load_word,
  output logic                 read_stb,
  output logic                 inc_stb,
  output logic                 prog_begin_stb,
  output logic                 prog_end_stb,
  output logic                 erase_stb,
  output logic                 seq_err
);

  localparam int FRAME_CLKS = DATA_BITS + 2;
  localparam int MAX_CNT    = (FRAME_CLKS > CMD_BITS) ? FRAME_CLKS : CMD_BITS;
  localparam int CNT_W      = $clog2(MAX_CNT);

  logic             pclk_rise;
  logic             pclk_fall;
  logic             pdat_s;
  phase_t           phase;
  logic [CNT_W-1:0] cnt;

  pcs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pclk_pin  (pclk_pin),
    .pdat_pin  (pdat_pin),
    .pclk_rise (pclk_rise),
    .pclk_fall (pclk_fall),
    .pdat_s    (pdat_s)
  );

  pcs_frame #(
    .CMD_BITS  (CMD_BITS),
    .DATA_BITS (DATA_BITS),
    .WORD_BITS (WORD_BITS),
    .CNT_W     (CNT_W)
  ) u_frame (
    .clk            (clk),
    .rst            (rst),
    .mode_rst       (mode_rst),
    .fall           (pclk_fall),
    .dat            (pdat_s),
    .phase          (phase),
    .cnt            (cnt),
    .load_stb       (load_stb),
    .load_word      (load_word),
    .read_stb       (read_stb),
    .inc_stb        (inc_stb),
    .prog_begin_stb (prog_begin_stb),
    .prog_end_stb   (prog_end_stb),
    .erase_stb      (erase_stb),
    .seq_err        (seq_err)
  );

  pcs_tx #(
    .DATA_BITS (DATA_BITS),
    .WORD_BITS (WORD_BITS),
    .CNT_W     (CNT_W)
  ) u_tx (
    .clk       (clk),
    .rst       (rst),
    .mode_rst  (mode_rst),
    .rise      (pclk_rise),
    .in_read   (phase == PH_READ),
    .cnt       (cnt),
    .mem_rdata (mem_rdata),
    .pdat_out  (pdat_out),
    .pdat_oe   (pdat_oe)
  );

endmodule

// File: tb/tb_prog_cmd_slave.sv
module tb_prog_cmd_slave;

  localparam int HALF = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        mode_rst = 1'b0;
  logic        pclk_pin = 1'b0;
  logic        pdat_pin = 1'b0;
  logic [11:0] mem_rdata = 12'h0;
  logic        pdat_out, pdat_oe, load_stb, read_stb, inc_stb;
  logic        prog_begin_stb, prog_end_stb, erase_stb, seq_err;
  logic [11:0] load_word;

  prog_cmd_slave dut (
    .clk(clk), .rst(rst), .mode_rst(mode_rst), .pclk_pin(pclk_pin),
    .pdat_pin(pdat_pin), .mem_rdata(mem_rdata), .pdat_out(pdat_out),
    .pdat_oe(pdat_oe), .load_stb(load_stb), .load_word(load_word),
    .read_stb(read_stb), .inc_stb(inc_stb), .prog_begin_stb(prog_begin_stb),
    .prog_end_stb(prog_end_stb), .erase_stb(erase_stb), .seq_err(seq_err)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // ---------------- memory/address unit stand-in ----------------
  logic [11:0] bmem [0:63];
  int          baddr = 0;
  logic [11:0] bbuf = 12'h0;
  int n_load = 0, n_read = 0, n_inc = 0, n_beg = 0, n_end = 0, n_era = 0, n_err = 0;

  initial for (int i = 0; i < 64; i++) bmem[i] = 12'((i * 37) & 12'hFFF);

  always @(posedge clk) begin
    if (rst) begin
      baddr = 0;
      n_load = 0; n_read = 0; n_inc = 0; n_beg = 0; n_end = 0; n_era = 0; n_err = 0;
    end else begin
      if (load_stb) begin bbuf = load_word; n_load++; end
      if (prog_begin_stb) begin bmem[baddr] = bbuf; n_beg++; end
      if (inc_stb) begin baddr = (baddr + 1) % 64; n_inc++; end
      if (erase_stb) begin
        for (int i = 0; i < 64; i++) bmem[i] = 12'hFFF;
        n_era++;
      end
      if (read_stb) begin mem_rdata <= bmem[baddr]; n_read++; end
      if (prog_end_stb) n_end++;
      if (seq_err) n_err++;
    end
  end

  // ---------------- cycle-by-cycle reference model ----------------
  int h1 = 0, h2 = 0, h3 = 0, dd1 = 0, dd2 = 0;
  int mph = 0, mcnt = 0, mop = 0, mword = 0, marmed = 0, mtx = 0;
  int e_oe = 0, e_out = 0, e_load = 0, e_word = 0, e_read = 0, e_inc = 0;
  int e_beg = 0, e_end = 0, e_era = 0, e_err = 0;

  always @(posedge clk) begin
    int rise_e, fall_e, d;
    if (rst) begin
      h1 = 0; h2 = 0; h3 = 0; dd1 = 0; dd2 = 0;
      mph = 0; mcnt = 0; mop = 0; mword = 0; marmed = 0; mtx = 0;
      e_oe = 0; e_out = 0; e_load = 0; e_word = 0; e_read = 0; e_inc = 0;
      e_beg = 0; e_end = 0; e_era = 0; e_err = 0;
    end else begin
      rise_e = (h2 == 1 && h3 == 0) ? 1 : 0;
      fall_e = (h2 == 0 && h3 == 1) ? 1 : 0;
      d = dd2;
      e_load = 0; e_read = 0; e_inc = 0; e_beg = 0; e_end = 0; e_era = 0; e_err = 0;
      if (mode_rst) begin
        mph = 0; mcnt = 0; marmed = 0; e_oe = 0; e_out = 0;
      end else begin
        if (mph != 2) begin
          e_oe = 0; e_out = 0;
        end else if (rise_e == 1) begin
          if (mcnt == 0) mtx = int'(mem_rdata);
          else if (mcnt <= 14) begin e_oe = 1; e_out = (mtx >> (mcnt - 1)) & 1; end
          else begin e_oe = 0; e_out = 0; end
        end
        if (fall_e == 1) begin
          if (mph == 0) begin
            if (mcnt == 0) mop = 0;
            if (mcnt < 4) mop = mop | (d << mcnt);
            if (mcnt == 5) begin
              mcnt = 0;
              case (mop)
                2:  mph = 1;
                4:  begin mph = 2; e_read = 1; end
                6:  e_inc = 1;
                8:  if (marmed == 1) begin e_beg = 1; marmed = 0; end else e_err = 1;
                14: e_end = 1;
                9:  e_era = 1;
                default: ;
              endcase
            end else mcnt++;
          end else begin
            if (mcnt == 0) mword = 0;
            if (mcnt >= 1 && mcnt <= 12) mword = mword | (d << (mcnt - 1));
            if (mcnt == 15) begin
              if (mph == 1) begin e_load = 1; e_word = mword; marmed = 1; end
              mph = 0; mcnt = 0;
            end else mcnt++;
          end
        end
      end
      h3 = h2; h2 = h1; h1 = int'(pclk_pin);
      dd2 = dd1; dd1 = int'(pdat_pin);
    end
  end

  always @(negedge clk) begin
    int act, expv;
    if (!rst) begin
      act  = {pdat_oe, pdat_out, load_stb, read_stb, inc_stb, prog_begin_stb,
              prog_end_stb, erase_stb, seq_err, load_word};
      expv = {e_oe[0], e_out[0], e_load[0], e_read[0], e_inc[0], e_beg[0],
              e_end[0], e_era[0], e_err[0], e_word[11:0]};
      chk(act == expv, "R10 per-cycle model (R1 R2 R4 R5 R6)", act, expv);
    end
  end

  // ---------------- host tasks ----------------
  task automatic pbit(input logic b);
    @(negedge clk);
    pclk_pin = 1'b1;
    pdat_pin = b;
    repeat (HALF) @(negedge clk);
    pclk_pin = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic gap();
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) pbit(c[i]);
    gap();
  endtask

  task automatic send_load(input logic [13:0] w, input logic st, input logic sp);
    pbit(st);
    for (int i = 0; i < 14; i++) pbit(w[i]);
    pbit(sp);
    gap();
  endtask

  task automatic do_read(output logic [13:0] w);
    w = '0;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      pclk_pin = 1'b1;
      pdat_pin = 1'b0;
      repeat (HALF) @(negedge clk);
      chk(pdat_oe == ((i >= 2 && i <= 15) ? 1'b1 : 1'b0), "R5 oe window",
          int'(pdat_oe), (i >= 2 && i <= 15) ? 1 : 0);
      if (i >= 2 && i <= 15) w[i-2] = pdat_out;
      pclk_pin = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    gap();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [13:0] rw;
    int prev;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk({pdat_oe, pdat_out, load_stb, read_stb, inc_stb, prog_begin_stb,
         prog_end_stb, erase_stb, seq_err} == 9'b0 && load_word == 12'h0,
        "R9 reset outputs", int'(load_word), 0);

    // R2 R3 R4: write-word with top command bits set and start/stop high
    send_cmd(6'b110010);
    send_load(14'h3A5C, 1'b1, 1'b1);
    chk(load_word == 12'hA5C, "R4 word low bits", int'(load_word), 12'hA5C);
    chk(n_load == 1, "R3 frame ended, load strobe", n_load, 1);

    // R6 start program with pending word
    send_cmd(6'b001000);
    chk(n_beg == 1 && n_err == 0, "R6 begin after load", n_beg, 1);
    send_cmd(6'b001110);
    chk(n_end == 1, "R2 end program", n_end, 1);
    // R6 second start without a write
    send_cmd(6'b001000);
    chk(n_beg == 1 && n_err == 1, "R6 begin without load", n_err, 1);

    // R5 fetch word 0
    send_cmd(6'b000100);
    chk(n_read == 1, "R5 read strobe", n_read, 1);
    do_read(rw);
    chk(rw == 14'h0A5C, "R5 fetched data", int'(rw), 14'h0A5C);

    // R1 R2 step address, write with zero start/stop, fetch back
    send_cmd(6'b100110);
    chk(n_inc == 1, "R1 step address", n_inc, 1);
    send_cmd(6'b000010);
    send_load(14'h1234, 1'b0, 1'b0);
    chk(load_word == 12'h234, "R4 second word", int'(load_word), 12'h234);
    send_cmd(6'b001000);
    send_cmd(6'b001110);
    send_cmd(6'b000100);
    do_read(rw);
    chk(rw == 14'h0234, "R5 fetched second", int'(rw), 14'h0234);

    // R7 unknown code, then a command follows directly
    prev = n_inc;
    send_cmd(6'b000011);
    send_cmd(6'b000110);
    chk(n_inc == prev + 1 && n_load == 2 && n_read == 2, "R7 unknown ignored",
        n_inc, prev + 1);

    // R8 mode reset in the middle of a command
    prev = n_inc;
    pbit(1'b0); pbit(1'b1); pbit(1'b1);
    @(negedge clk) mode_rst = 1'b1;
    @(negedge clk) mode_rst = 1'b0;
    send_cmd(6'b000110);
    chk(n_inc == prev + 1, "R8 mid-command reset", n_inc, prev + 1);

    // R8 mode reset in the middle of a data frame
    prev = n_inc;
    send_cmd(6'b000010);
    for (int i = 0; i < 5; i++) pbit(1'b1);
    @(negedge clk) mode_rst = 1'b1;
    @(negedge clk) mode_rst = 1'b0;
    send_cmd(6'b000110);
    chk(n_inc == prev + 1 && n_load == 2, "R8 mid-frame reset", n_inc, prev + 1);

    // R8 mode reset forgets a pending word
    send_cmd(6'b000010);
    send_load(14'h0055, 1'b0, 1'b0);
    @(negedge clk) mode_rst = 1'b1;
    @(negedge clk) mode_rst = 1'b0;
    prev = n_err;
    send_cmd(6'b001000);
    chk(n_err == prev + 1 && n_beg == 2, "R8 pending word cleared", n_err, prev + 1);

    // R2 R5 bulk erase, top data bits read as zero
    send_cmd(6'b011001);
    chk(n_era == 1, "R2 bulk erase", n_era, 1);
    send_cmd(6'b000100);
    do_read(rw);
    chk(rw == 14'h0FFF, "R5 erased word top bits zero", int'(rw), 14'h0FFF);

    // R11 no overlapping strobe counts beyond the issued commands
    chk(n_load + n_read + n_inc + n_beg + n_end + n_era + n_err == 3 + 3 + 4 + 2 + 2 + 1 + 2,
        "R11 strobe totals", n_load + n_read + n_inc + n_beg + n_end + n_era + n_err, 17);

    repeat (10) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule